// File: doc/BRIEF.md
# Predicate Register Redirection Table

This block keeps sixteen predication configuration slots that software fills through a simple write port. Each slot names one architectural register and says whether it belongs to the integer or the floating-point file. It also names the predicate register that actually supplies the mask for that register, and it carries three mode flags: zero the masked-off elements, invert the mask before use, and fail-on-first.

Instruction decode presents a 7-bit register number and a file-select bit. In the same cycle the table answers whether that register is predicated. On a hit it returns the redirect index and the three mode flags. The block keeps one lookup view for each register file and picks one with the file-select bit. When several slots name the same register in the same file, the slot with the larger number wins. The same result would come from applying slots 0 to 15 in order, with later ones overwriting earlier ones.

Top module: `predtab_top`

## Requirements
- R1: A synchronous reset empties every slot, so in the cycle after reset every lookup misses.
- R2: A write with `wr_en` high stores `wr_data` into slot `wr_addr` on the rising clock edge, and the next lookup sees the new contents.
- R3: A lookup hits when a written slot has its register field (bits 7..1) equal to `lk_reg` and its file bit (bit 8, 0 = integer, 1 = floating point) equal to `lk_fp`. On a hit `lk_preg` is that slot's bits 15..11.
- R4: On a hit, `lk_zero` is slot bit 10, `lk_inv` is slot bit 9 and `lk_ffirst` is slot bit 0.
- R5: A slot written for one file never hits a lookup on the other file, even when the register number is the same.
- R6: When more than one written slot matches a lookup, the result comes from the slot with the highest number.
- R7: A lookup that misses drives `lk_hit`, `lk_preg`, `lk_zero`, `lk_inv` and `lk_ffirst` all to 0.
- R8: With `wr_en` low, the table does not change, whatever `wr_addr` and `wr_data` carry.
- R9: Writing a slot again replaces its old mapping completely. The old register then falls back to any lower-numbered match, or misses.
- R10: The whole 7-bit register range is usable, including register 0 with an all-zero slot word and register 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for a slot |
| wr_addr | input | 4 | Slot number to write |
| wr_data | input | 16 | Slot word: [15:11] predicate register, [10] zero, [9] invert, [8] file, [7:1] register, [0] fail-on-first |
| lk_reg | input | 7 | Register number being looked up |
| lk_fp | input | 1 | File of the lookup: 0 integer, 1 floating point |
| lk_hit | output | 1 | Register is predicated |
| lk_preg | output | 5 | Redirected predicate register |
| lk_zero | output | 1 | Zeroing mode of the hit |
| lk_inv | output | 1 | Invert mode of the hit |
| lk_ffirst | output | 1 | Fail-on-first mode of the hit |

## Verification
The bench writes several slots that share a register number. In one case the slots belong to different files: a design that ignored the file bit would report the other file's redirect. In another case a lower-numbered slot is written after a higher-numbered one that names the same register: a design that let the last write win, instead of the highest slot number, would return the stale redirect. Two further cases are an all-zero slot word and an overwritten slot. Without a per-slot valid flag, an empty table would look as if register 0 were predicated. A design that never cleared an old match would keep a register predicated after its only slot had moved elsewhere. A long pseudo-random run over a narrow range of registers compares every cycle against a behavioural model. That run also covers writes with the strobe low, which must leave the table untouched.

// File: rtl/predtab_pkg.sv
package predtab_pkg;

    localparam int NUM_SLOTS = 16;
    localparam int SLOT_AW   = $clog2(NUM_SLOTS);
    localparam int REG_W     = 7;
    localparam int PREG_W    = 5;
    localparam int SLOT_W    = PREG_W + 3 + REG_W + 1;

    // Field order follows the software-visible slot word, MSB first.
    typedef struct packed {
        logic [PREG_W-1:0] preg;
        logic              zero;
        logic              inv;
        logic              fp;
        logic [REG_W-1:0]  regnum;
        logic              ffirst;
    } slot_t;

    typedef struct packed {
        logic              hit;
        logic [PREG_W-1:0] preg;
        logic              zero;
        logic              inv;
        logic              ffirst;
    } lookup_t;

endpackage

// File: rtl/predtab_store.sv
module predtab_store
    import predtab_pkg::*;
#(
    parameter int N  = NUM_SLOTS,
    localparam int AW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  slot_t               wr_slot,
    output slot_t [N-1:0]       slot_q,
    output logic  [N-1:0]       valid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= '0;
            valid_q <= '0;
        end else if (wr_en) begin
            slot_q[wr_addr]  <= wr_slot;
            valid_q[wr_addr] <= 1'b1;
        end
    end

endmodule

// File: rtl/predtab_view.sv
module predtab_view
    import predtab_pkg::*;
#(
    parameter int   N      = NUM_SLOTS,
    parameter logic FP_SEL = 1'b0
) (
    input  slot_t [N-1:0]      slot_q,
    input  logic  [N-1:0]      valid_q,
    input  logic [REG_W-1:0]   lk_reg,
    output lookup_t            res
);

    // Priority chain: a later (higher-numbered) slot overrides earlier ones.
    lookup_t chain [N+1];

    assign chain[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic match;
        assign match = valid_q[i]
                    && (slot_q[i].fp == FP_SEL)
                    && (slot_q[i].regnum == lk_reg);
        assign chain[i+1] = match
            ? '{hit: 1'b1, preg: slot_q[i].preg, zero: slot_q[i].zero,
                inv: slot_q[i].inv, ffirst: slot_q[i].ffirst}
            : chain[i];
    end

    assign res = chain[N];

endmodule

// File: rtl/predtab_top.sv
module predtab_top
    import predtab_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SLOT_AW-1:0]  wr_addr,
    input  logic [SLOT_W-1:0]   wr_data,
    input  logic [REG_W-1:0]    lk_reg,
    input  logic                lk_fp,
    output logic                lk_hit,
    output logic [PREG_W-1:0]   lk_preg,
    output logic                lk_zero,
    output logic                lk_inv,
    output logic                lk_ffirst
);

    slot_t [NUM_SLOTS-1:0] slot_q;
    logic  [NUM_SLOTS-1:0] valid_q;
    lookup_t               view_res [2];
    lookup_t               sel;

    predtab_store #(.N(NUM_SLOTS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_slot (slot_t'(wr_data)),
        .slot_q  (slot_q),
        .valid_q (valid_q)
    );

    // One lookup view per register file.
    for (genvar v = 0; v < 2; v++) begin : g_view
        predtab_view #(.N(NUM_SLOTS), .FP_SEL(1'(v))) u_view (
            .slot_q  (slot_q),
            .valid_q (valid_q),
            .lk_reg  (lk_reg),
            .res     (view_res[v])
        );
    end

    assign sel       = lk_fp ? view_res[1] : view_res[0];
    assign lk_hit    = sel.hit;
    assign lk_preg   = sel.preg;
    assign lk_zero   = sel.zero;
    assign lk_inv    = sel.inv;
    assign lk_ffirst = sel.ffirst;

endmodule

// File: rtl/predtab_chk.sv
module predtab_chk
    import predtab_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SLOT_AW-1:0]  wr_addr,
    input  logic [SLOT_W-1:0]   wr_data,
    input  logic [REG_W-1:0]    lk_reg,
    input  logic                lk_fp,
    input  logic                lk_hit,
    input  logic [PREG_W-1:0]   lk_preg,
    input  logic                lk_zero,
    input  logic                lk_inv,
    input  logic                lk_ffirst
);

    localparam logic [SLOT_AW-1:0] TOP_SLOT = SLOT_AW'(NUM_SLOTS - 1);

    // R1: the cycle after reset sees an empty table
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !lk_hit);

    // R2, R3: a write to the top slot is visible at once with its redirect
    p_write_visible_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(wr_addr) == TOP_SLOT
         && lk_reg == $past(wr_data[7:1]) && lk_fp == $past(wr_data[8]))
        |-> (lk_hit && lk_preg == $past(wr_data[15:11])));

    // R4: mode flags of the top slot reach the outputs
    p_mode_bits_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(wr_addr) == TOP_SLOT
         && lk_reg == $past(wr_data[7:1]) && lk_fp == $past(wr_data[8]))
        |-> (lk_zero == $past(wr_data[10]) && lk_inv == $past(wr_data[9])
             && lk_ffirst == $past(wr_data[0])));

    // R7: a miss drives every field low
    p_miss_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_preg == '0 && !lk_zero && !lk_inv && !lk_ffirst));

    // R8: no write and same lookup key means the same answer
    p_no_write_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && $stable(lk_reg) && $stable(lk_fp))
        |-> $stable({lk_hit, lk_preg, lk_zero, lk_inv, lk_ffirst}));

endmodule

bind predtab_top predtab_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .lk_reg    (lk_reg),
    .lk_fp     (lk_fp),
    .lk_hit    (lk_hit),
    .lk_preg   (lk_preg),
    .lk_zero   (lk_zero),
    .lk_inv    (lk_inv),
    .lk_ffirst (lk_ffirst)
);

// File: tb/tb_predtab_top.sv
`timescale 1ns/1ps
module tb_predtab_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [6:0]  lk_reg = '0;
    logic        lk_fp = 1'b0;
    logic        lk_hit;
    logic [4:0]  lk_preg;
    logic        lk_zero, lk_inv, lk_ffirst;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Behavioural reference: slot words plus a written flag per slot.
    logic [15:0] ref_word [16];
    bit          ref_valid [16];

    always #2 clk = ~clk;   // 250 MHz

    predtab_top dut (.*);

    function automatic logic [8:0] ref_lookup(input logic [6:0] r, input logic f);
        logic [8:0] res = '0;
        for (int i = 0; i < 16; i++)
            if (ref_valid[i] && ref_word[i][7:1] == r && ref_word[i][8] == f)
                res = {1'b1, ref_word[i][15:11], ref_word[i][10], ref_word[i][9], ref_word[i][0]};
        return res;
    endfunction

    function automatic logic [15:0] mk(input logic [4:0] p, input logic z, input logic iv,
                                       input logic f, input logic [6:0] r, input logic ff);
        return {p, z, iv, f, r, ff};
    endfunction

    // One cycle: drive at negedge, compare before the edge, update model at edge.
    task automatic step(input logic we, input logic [3:0] a, input logic [15:0] d,
                        input logic [6:0] r, input logic f, input string tag);
        logic [8:0] got, exp;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; lk_reg = r; lk_fp = f;
        #1;
        got = {lk_hit, lk_preg, lk_zero, lk_inv, lk_ffirst};
        exp = ref_lookup(r, f);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s reg=%0d fp=%0d got=%b exp=%b", tag, r, f, got, exp);
        end
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 16; i++) ref_valid[i] = 0;
        end else if (we) begin
            ref_word[a] = d;
            ref_valid[a] = 1;
        end
    endtask

    task automatic look(input logic [6:0] r, input logic f, input string tag);
        step(1'b0, 4'd0, 16'h0, r, f, tag);
    endtask

    task automatic write(input logic [3:0] a, input logic [15:0] d, input string tag);
        step(1'b1, a, d, 7'd0, 1'b0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        step(1'b0, 4'd0, 16'h0, 7'd0, 1'b0, "R1");
        step(1'b0, 4'd0, 16'h0, 7'd0, 1'b0, "R1");
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        int unsigned s = 32'h1234_5678;
        for (int i = 0; i < 16; i++) begin ref_valid[i] = 0; ref_word[i] = '0; end
        do_reset();

        // R1, R7: empty table misses everywhere
        look(7'd0, 1'b0, "R1");
        look(7'd5, 1'b1, "R7");
        look(7'd127, 1'b0, "R7");

        // R2, R3, R4: basic write then lookup
        write(4'd3, mk(5'd9, 1'b1, 1'b0, 1'b0, 7'd5, 1'b1), "R2");
        look(7'd5, 1'b0, "R3");
        look(7'd5, 1'b0, "R4");
        look(7'd6, 1'b0, "R7");
        // R5: same register, other file
        look(7'd5, 1'b1, "R5");
        write(4'd7, mk(5'd20, 1'b0, 1'b1, 1'b1, 7'd5, 1'b0), "R5");
        look(7'd5, 1'b1, "R5");
        look(7'd5, 1'b0, "R5");

        // R6: higher slot wins, independent of write order
        write(4'd10, mk(5'd2, 1'b0, 1'b1, 1'b0, 7'd5, 1'b0), "R6");
        look(7'd5, 1'b0, "R6");
        write(4'd1, mk(5'd30, 1'b1, 1'b1, 1'b0, 7'd5, 1'b1), "R6");
        look(7'd5, 1'b0, "R6");

        // R8: strobe low leaves slot 10 alone
        step(1'b0, 4'd10, mk(5'd17, 1'b1, 1'b0, 1'b0, 7'd9, 1'b1), 7'd5, 1'b0, "R8");
        look(7'd5, 1'b0, "R8");
        look(7'd9, 1'b0, "R8");

        // R9, R10: overwrite slot 10 to register 127
        write(4'd10, mk(5'd31, 1'b1, 1'b1, 1'b0, 7'd127, 1'b1), "R9");
        look(7'd5, 1'b0, "R9");
        look(7'd127, 1'b0, "R10");
        write(4'd0, 16'h0000, "R10");
        look(7'd0, 1'b0, "R10");
        look(7'd0, 1'b1, "R10");

        // Pseudo-random run on a narrow register range
        for (int n = 0; n < 600; n++) begin
            s = s * 32'd1103515245 + 32'd12345;
            step(s[30], s[19:16],
                 {s[24:20], s[25], s[26], s[27], 3'b000, s[31:28], s[8]},
                 {3'b000, s[12:9]}, s[13], s[30] ? "R2" : "R8");
        end

        // R1: reset mid-run empties the table
        do_reset();
        look(7'd5, 1'b0, "R1");
        look(7'd0, 1'b0, "R1");

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule